// File: doc/BRIEF.md
# Package Idle-State Resolution Controller

This block settles the idle power level of a whole multi-core package. Each core posts a two-bit idle request. The block samples these requests as a group and takes the shallowest of them as the package goal. It then limits that goal by the platform's permissions and by a demotion flag that an external heuristic unit drives. The registered result is the package state, and it can step straight from one idle level to another.

Break events pull the package out of an idle level. An unmasked core break wakes the addressed core and brings the package to the active level. A masked core break makes one short pass through the active level and then re-enters the level held before. A memory or snoop break opens a fixed service window. At the end of that window the package either goes back to its earlier level or, if the platform asks for it, stays active.

Top module: `pkg_idle_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `pkg_state` is C0, `wake_req` is all zero and `svc_busy` is low. Every stored core request reads as C0 until the first sample.
- R2: The level codes are C0=0, C1=1 and C6=2. A request code of 3 is stored as C6. On a cycle with `req_valid` high the requests are captured, and two clock edges after that input cycle `pkg_state` shows the smallest stored code, subject to R3 and R4.
- R3: A C6 goal with `allow_c6` low becomes C1 if `allow_c1` is high and C0 if it is low. A C1 goal with `allow_c1` low becomes C0.
- R4: A C6 goal with `demote` high is limited in the same way as a C6 goal without permission (C1, or C0 when C1 is not allowed).
- R5: When the package is idle, a change of goal between C1 and C6 moves `pkg_state` directly from one to the other, without a C0 cycle between them.
- R6: An unmasked core break (`brk_core` high, `brk_mask` low) while the package is idle and resolving sets `pkg_state` to C0 and pulses the one-hot bit of `brk_target` on `wake_req` for exactly one cycle. The stored request of that core becomes C0, so the package stays in C0 until a new sample arrives.
- R7: A masked core break while the package is idle gives one cycle of C0 and then returns to the level held before the break. `wake_req` stays zero.
- R8: A memory or snoop break (`brk_mem`) while the package is idle raises `svc_busy` for exactly SVC_CYCLES cycles with `pkg_state` at C0. If `plat_hold` is low at the end of the window, the package returns to its earlier level.
- R9: If `plat_hold` is high when the service window ends, `pkg_state` stays C0 for as long as `plat_hold` stays high. Resolution resumes one cycle after `plat_hold` falls.
- R10: Break inputs are ignored while the package is in C0, during a service window, during a re-entry cycle and during a hold. When breaks arrive in the same cycle, an unmasked core break takes priority over a memory break, and a memory break takes priority over a masked core break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req | input | 2*NUM_CORES | Idle request codes, core i at bits [2i+1:2i] |
| req_valid | input | 1 | Sample core_req this cycle |
| allow_c1 | input | 1 | Platform permits package C1 |
| allow_c6 | input | 1 | Platform permits package C6 |
| demote | input | 1 | Auto-demotion flag from the heuristic unit |
| plat_hold | input | 1 | Platform asks to keep the package active after a service |
| brk_core | input | 1 | Core break event |
| brk_mask | input | 1 | The core break is masked |
| brk_target | input | CW | Index of the core the break is aimed at |
| brk_mem | input | 1 | Memory-access or snoop break event |
| pkg_state | output | 2 | Registered package level |
| wake_req | output | NUM_CORES | One-cycle one-hot wake pulse |
| svc_busy | output | 1 | Memory or snoop service window is open |

## Verification
Two collisions matter most. The first is a core break and a memory break in the same cycle. The unmasked core break must win: the bench expects a wake pulse and no busy window. With the mask set, the memory break must win instead. The second is a new request sample that lands in the same cycle as an unmasked wake. The wake's override of the targeted core must take priority over the freshly sampled code for that core. The bench drives both collisions on purpose and also lets random traffic produce them. It judges each cycle against a level model built from the requirements.

// File: rtl/pkg_idle_pkg.sv
package pkg_idle_pkg;
  localparam logic [1:0] CST_C0 = 2'd0;
  localparam logic [1:0] CST_C1 = 2'd1;
  localparam logic [1:0] CST_C6 = 2'd2;

  typedef enum logic [1:0] {
    MD_RUN     = 2'd0,
    MD_SVC     = 2'd1,
    MD_REENTER = 2'd2,
    MD_HOLD    = 2'd3
  } mode_t;
endpackage

// File: rtl/req_store.sv
module req_store #(
  parameter int NUM_CORES = 4,
  localparam int CW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic [2*NUM_CORES-1:0] core_req,
  input  logic                   clr_en,
  input  logic [CW-1:0]          clr_idx,
  output logic [2*NUM_CORES-1:0] req_q
);
  import pkg_idle_pkg::*;

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    logic [1:0] norm;
    assign norm = (core_req[2*g +: 2] == 2'd3) ? CST_C6 : core_req[2*g +: 2];

    always_ff @(posedge clk) begin
      if (rst) begin
        req_q[2*g +: 2] <= CST_C0;
      end else if (clr_en && (clr_idx == CW'(g))) begin
        req_q[2*g +: 2] <= CST_C0;
      end else if (req_valid) begin
        req_q[2*g +: 2] <= norm;
      end
    end
  end
endmodule

// File: rtl/req_min.sv
module req_min #(
  parameter int NUM_CORES = 4
) (
  input  logic [2*NUM_CORES-1:0] req_q,
  output logic [1:0]             min_code
);
  import pkg_idle_pkg::*;

  logic [1:0] chain [NUM_CORES+1];
  assign chain[0] = CST_C6;

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_min
    assign chain[g+1] = (req_q[2*g +: 2] < chain[g]) ? req_q[2*g +: 2] : chain[g];
  end

  assign min_code = chain[NUM_CORES];
endmodule

// File: rtl/target_clamp.sv
module target_clamp (
  input  logic [1:0] want,
  input  logic       allow_c1,
  input  logic       allow_c6,
  input  logic       demote,
  output logic [1:0] tgt
);
  import pkg_idle_pkg::*;

  logic [1:0] shallow;
  assign shallow = allow_c1 ? CST_C1 : CST_C0;

  always_comb begin
    tgt = want;
    if (want == CST_C6 && (!allow_c6 || demote)) begin
      tgt = shallow;
    end else if (want == CST_C1 && !allow_c1) begin
      tgt = CST_C0;
    end
  end
endmodule

// File: rtl/pkg_idle_ctrl.sv
module pkg_idle_ctrl #(
  parameter int NUM_CORES  = 4,
  parameter int SVC_CYCLES = 4,
  localparam int CW   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int CNTW = $clog2(SVC_CYCLES + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [2*NUM_CORES-1:0] core_req,
  input  logic                   req_valid,
  input  logic                   allow_c1,
  input  logic                   allow_c6,
  input  logic                   demote,
  input  logic                   plat_hold,
  input  logic                   brk_core,
  input  logic                   brk_mask,
  input  logic [CW-1:0]          brk_target,
  input  logic                   brk_mem,
  output logic [1:0]             pkg_state,
  output logic [NUM_CORES-1:0]   wake_req,
  output logic                   svc_busy
);
  import pkg_idle_pkg::*;

  logic [2*NUM_CORES-1:0] req_q;
  logic [1:0]             min_code;
  logic [1:0]             tgt;
  logic [1:0]             pkg_q;
  logic [1:0]             saved_q;
  mode_t                  mode_q;
  logic [CNTW-1:0]        cnt_q;
  logic                   busy_q;
  logic [NUM_CORES-1:0]   wake_q;
  logic [NUM_CORES-1:0]   wake_vec;
  logic                   idle_run;
  logic                   do_wake;

  assign idle_run = (mode_q == MD_RUN) && (pkg_q != CST_C0);
  assign do_wake  = idle_run && brk_core && !brk_mask;

  always_comb begin
    wake_vec = '0;
    if (int'(brk_target) < NUM_CORES) wake_vec[brk_target] = 1'b1;
  end

  req_store #(.NUM_CORES(NUM_CORES)) u_store (
    .clk(clk), .rst(rst), .req_valid(req_valid), .core_req(core_req),
    .clr_en(do_wake), .clr_idx(brk_target), .req_q(req_q)
  );

  req_min #(.NUM_CORES(NUM_CORES)) u_min (
    .req_q(req_q), .min_code(min_code)
  );

  target_clamp u_clamp (
    .want(min_code), .allow_c1(allow_c1), .allow_c6(allow_c6),
    .demote(demote), .tgt(tgt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pkg_q   <= CST_C0;
      saved_q <= CST_C0;
      mode_q  <= MD_RUN;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      wake_q  <= '0;
    end else begin
      wake_q <= '0;
      case (mode_q)
        MD_RUN: begin
          if (do_wake) begin
            pkg_q  <= CST_C0;
            wake_q <= wake_vec;
          end else if (idle_run && brk_mem) begin
            saved_q <= pkg_q;
            pkg_q   <= CST_C0;
            mode_q  <= MD_SVC;
            cnt_q   <= CNTW'(SVC_CYCLES - 1);
            busy_q  <= 1'b1;
          end else if (idle_run && brk_core) begin
            saved_q <= pkg_q;
            pkg_q   <= CST_C0;
            mode_q  <= MD_REENTER;
          end else begin
            pkg_q <= tgt;
          end
        end
        MD_SVC: begin
          if (cnt_q == '0) begin
            busy_q <= 1'b0;
            if (plat_hold) begin
              mode_q <= MD_HOLD;
            end else begin
              pkg_q  <= saved_q;
              mode_q <= MD_RUN;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        MD_REENTER: begin
          pkg_q  <= saved_q;
          mode_q <= MD_RUN;
        end
        MD_HOLD: begin
          if (!plat_hold) mode_q <= MD_RUN;
        end
        default: mode_q <= MD_RUN;
      endcase
    end
  end

  assign pkg_state = pkg_q;
  assign wake_req  = wake_q;
  assign svc_busy  = busy_q;
endmodule

// File: rtl/pkg_idle_chk.sv
module pkg_idle_chk #(
  parameter int NUM_CORES  = 4,
  parameter int SVC_CYCLES = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic [1:0]           pkg_state,
  input logic [NUM_CORES-1:0] wake_req,
  input logic                 svc_busy
);
  int busy_run;

  always_ff @(posedge clk) begin
    if (rst)           busy_run <= 0;
    else if (svc_busy) busy_run <= busy_run + 1;
    else               busy_run <= 0;
  end

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst) pkg_state != 2'd3); // R2
  AST_WAKE_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(wake_req)); // R6
  AST_WAKE_ACTIVE: assert property (@(posedge clk) disable iff (rst) (|wake_req) |-> pkg_state == 2'd0); // R6
  AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (rst) (|wake_req) |=> wake_req == '0); // R6
  AST_WAKE_FROM_IDLE: assert property (@(posedge clk) disable iff (rst) (|wake_req) |-> $past(pkg_state) != 2'd0); // R10
  AST_BUSY_ACTIVE: assert property (@(posedge clk) disable iff (rst) svc_busy |-> pkg_state == 2'd0); // R8
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (rst) svc_busy |-> busy_run < SVC_CYCLES); // R8
  AST_BUSY_FULL: assert property (@(posedge clk) disable iff (rst) $fell(svc_busy) |-> busy_run == SVC_CYCLES); // R8
  AST_NO_WAKE_IN_SVC: assert property (@(posedge clk) disable iff (rst) svc_busy |-> wake_req == '0); // R10
endmodule

bind pkg_idle_ctrl pkg_idle_chk #(.NUM_CORES(NUM_CORES), .SVC_CYCLES(SVC_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .pkg_state(pkg_state), .wake_req(wake_req), .svc_busy(svc_busy)
);

// File: tb/sim_pkg_idle_ctrl.sv
module sim_pkg_idle_ctrl;
  localparam int NC  = 4;
  localparam int SVC = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2*NC-1:0] core_req = '0;
  logic          req_valid = 0, allow_c1 = 1, allow_c6 = 1, demote = 0, plat_hold = 0;
  logic          brk_core = 0, brk_mask = 0, brk_mem = 0;
  logic [1:0]    brk_target = '0;
  logic [1:0]    pkg_state;
  logic [NC-1:0] wake_req;
  logic          svc_busy;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pkg_idle_ctrl #(.NUM_CORES(NC), .SVC_CYCLES(SVC)) u0 (
    .clk(clk), .rst(rst), .core_req(core_req), .req_valid(req_valid),
    .allow_c1(allow_c1), .allow_c6(allow_c6), .demote(demote), .plat_hold(plat_hold),
    .brk_core(brk_core), .brk_mask(brk_mask), .brk_target(brk_target), .brk_mem(brk_mem),
    .pkg_state(pkg_state), .wake_req(wake_req), .svc_busy(svc_busy)
  );

  // reference model state (modes: 0 run, 1 service, 2 re-entry, 3 hold)
  logic [1:0]    m_req [NC];
  logic [1:0]    m_pkg, m_saved;
  int            m_mode, m_cnt;
  logic          m_busy;
  logic [NC-1:0] m_wake;

  function automatic logic [1:0] limit(input logic [1:0] w, input logic a1, a6, dm);
    if (w == 2'd2 && (!a6 || dm)) return a1 ? 2'd1 : 2'd0;
    if (w == 2'd1 && !a1) return 2'd0;
    return w;
  endfunction

  function automatic logic [1:0] goal();
    logic [1:0] m = 2'd2;
    for (int i = 0; i < NC; i++) if (m_req[i] < m) m = m_req[i];
    return limit(m, allow_c1, allow_c6, demote);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NC; i++) m_req[i] = 2'd0;
    m_pkg = 0; m_saved = 0; m_mode = 0; m_cnt = 0; m_busy = 0; m_wake = '0;
  endtask

  task automatic model_step();
    logic [1:0] t = goal();
    logic [1:0] nreq [NC];
    logic idle = (m_mode == 0) && (m_pkg != 0);
    for (int i = 0; i < NC; i++) begin
      logic [1:0] c = core_req[2*i +: 2];
      nreq[i] = req_valid ? ((c == 2'd3) ? 2'd2 : c) : m_req[i];
    end
    m_wake = '0;
    case (m_mode)
      0: if (idle && brk_core && !brk_mask) begin
           m_pkg = 0; m_wake[brk_target] = 1'b1; nreq[brk_target] = 2'd0;
         end else if (idle && brk_mem) begin
           m_saved = m_pkg; m_pkg = 0; m_mode = 1; m_cnt = SVC - 1; m_busy = 1;
         end else if (idle && brk_core) begin
           m_saved = m_pkg; m_pkg = 0; m_mode = 2;
         end else m_pkg = t;
      1: if (m_cnt == 0) begin
           m_busy = 0;
           if (plat_hold) m_mode = 3; else begin m_pkg = m_saved; m_mode = 0; end
         end else m_cnt--;
      2: begin m_pkg = m_saved; m_mode = 0; end
      default: if (!plat_hold) m_mode = 0;
    endcase
    for (int i = 0; i < NC; i++) m_req[i] = nreq[i];
  endtask

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0d expected=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    if (rst) model_reset(); else model_step();
    @(negedge clk);
    check({tag, " pkg_state"}, pkg_state, m_pkg);
    check({tag, " wake_req"}, wake_req, m_wake);
    check({tag, " svc_busy"}, svc_busy, m_busy);
  endtask

  task automatic quiet();
    req_valid = 0; brk_core = 0; brk_mem = 0; brk_mask = 0;
  endtask

  task automatic sample(input logic [2*NC-1:0] r, input string tag);
    core_req = r; req_valid = 1; cyc(tag); req_valid = 0; cyc(tag);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int sum_busy;
    void'($urandom(32'd4711));
    model_reset();
    rst = 1; repeat (3) cyc("R1");
    rst = 0; cyc("R1");
    check("R1 reset pkg", pkg_state, 0);
    check("R1 reset busy", svc_busy, 0);

    // R2: all C6, then one core at C1, then all code 3
    sample(8'b10_10_10_10, "R2"); check("R2 all C6", pkg_state, 2);
    sample(8'b10_01_10_10, "R2"); check("R2 min C1", pkg_state, 1);
    sample(8'b11_11_11_11, "R2"); check("R2 code3 as C6", pkg_state, 2);

    // R5: direct C6 -> C1 -> C6 with no C0 in between
    core_req = 8'b01_10_10_10; req_valid = 1; cyc("R5"); req_valid = 0;
    check("R5 no C0 step", pkg_state == 0, 0);
    cyc("R5"); check("R5 direct C1", pkg_state, 1);
    core_req = 8'b10_10_10_10; req_valid = 1; cyc("R5"); req_valid = 0;
    check("R5 no C0 step back", pkg_state == 0, 0);
    cyc("R5"); check("R5 direct C6", pkg_state, 2);

    // R3 permissions, R4 demotion
    allow_c6 = 0; cyc("R3"); check("R3 no C6 -> C1", pkg_state, 1);
    allow_c1 = 0; cyc("R3"); check("R3 no C6 no C1 -> C0", pkg_state, 0);
    allow_c1 = 1; allow_c6 = 1; cyc("R3");
    sample(8'b01_01_01_01, "R3"); allow_c1 = 0; cyc("R3");
    check("R3 C1 denied", pkg_state, 0);
    allow_c1 = 1; sample(8'b10_10_10_10, "R4");
    demote = 1; cyc("R4"); check("R4 demote C1", pkg_state, 1);
    allow_c1 = 0; cyc("R4"); check("R4 demote C0", pkg_state, 0);
    allow_c1 = 1; demote = 0; cyc("R4"); check("R4 release", pkg_state, 2);

    // R7: masked core break from C6
    brk_core = 1; brk_mask = 1; brk_target = 2'd1; cyc("R7"); quiet();
    check("R7 C0 pass", pkg_state, 0); check("R7 no wake", wake_req, 0);
    cyc("R7"); check("R7 restore", pkg_state, 2);

    // R8: memory break, no hold
    brk_mem = 1; cyc("R8"); quiet(); sum_busy = 0;
    for (int k = 0; k < 6; k++) begin sum_busy += svc_busy; cyc("R8"); end
    check("R8 busy length", sum_busy, SVC);
    check("R8 restored", pkg_state, 2);

    // R9: memory break with platform hold
    plat_hold = 1; brk_mem = 1; cyc("R9"); quiet();
    repeat (SVC + 3) cyc("R9");
    check("R9 held C0", pkg_state, 0);
    // R10: breaks ignored while holding
    brk_core = 1; brk_target = 2'd0; cyc("R10"); quiet();
    check("R10 ignored in hold", wake_req, 0);
    plat_hold = 0; cyc("R9"); cyc("R9"); check("R9 resumes", pkg_state, 2);

    // R10: simultaneous unmasked core + memory break, plus sample in same cycle (R6)
    brk_core = 1; brk_mem = 1; brk_target = 2'd2;
    core_req = 8'b10_10_10_10; req_valid = 1; cyc("R10"); quiet();
    check("R10 core beats mem wake", wake_req, 4'b0100);
    check("R10 core beats mem busy", svc_busy, 0);
    cyc("R6"); check("R6 pulse ends", wake_req, 0);
    repeat (3) cyc("R6"); check("R6 stays C0", pkg_state, 0);
    // R10: breaks in C0 ignored
    brk_core = 1; brk_mem = 1; cyc("R10"); quiet();
    check("R10 C0 no wake", wake_req, 0); check("R10 C0 no busy", svc_busy, 0);
    sample(8'b01_01_01_01, "R10");
    brk_core = 1; brk_mask = 1; brk_mem = 1; cyc("R10"); quiet();
    check("R10 mem beats masked", svc_busy, 1);
    repeat (SVC + 1) cyc("R8");

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      req_valid  = ($urandom_range(7) == 0);
      core_req   = 8'($urandom);
      allow_c1   = ($urandom_range(9) != 0);
      allow_c6   = ($urandom_range(5) != 0);
      demote     = ($urandom_range(7) == 0);
      plat_hold  = ($urandom_range(2) == 0);
      brk_core   = ($urandom_range(9) == 0);
      brk_mask   = $urandom_range(1);
      brk_target = 2'($urandom);
      brk_mem    = ($urandom_range(11) == 0);
      cyc("R2");
    end

    done = 1;
    summary();
    $finish;
  end
endmodule